// File: doc/BRIEF.md
# Six-Channel Sequential Pixel Loader

This block distributes a stream of 10-bit pixel words across six channel holding registers and hands complete sets of six codes to six DAC inputs. A pixel clock marks each word. The block runs from a faster system clock, samples the pixel clock as a data input, and reacts to the edge that the edge-select input picks. A start strobe arms a loading run. On the following active edges, six consecutive words are written to the channels in ascending or descending order. After the sixth word, the run stops.

A separate transfer strobe, sampled on rising pixel-clock edges, copies all six held words into the output registers on the next rising edge. Loading and output updates therefore proceed independently, and several such blocks can share one pixel bus. Each word carries its own polarity flag, which stores the complemented code. A standby input freezes the whole block.

The loader is a four-state machine:

- `ST_IDLE`: after reset, no run in progress.
- `ST_ARMED`: a start strobe was seen; the next active edge writes the first channel.
- `ST_LOAD`: channels two to six are being written.
- `ST_FULL`: six words have been stored.

The transitions are:

- any state to `ST_ARMED` on an active edge with the start strobe high;
- `ST_ARMED` to `ST_LOAD` on the first word;
- `ST_LOAD` to `ST_LOAD` on the second to fifth words;
- `ST_LOAD` to `ST_FULL` on the sixth word;
- `ST_IDLE` and `ST_FULL` hold until the next start.

Top module: `pixel_chan_loader`

## Requirements
- R1: `dac_code` carries six 10-bit unsigned binary codes; channel k occupies bits [10k+9:10k].
- R2: During a run, each active edge stores the present word into exactly one channel, and six consecutive active edges fill all six channels.
- R3: With `rise_sel` high, a low-to-high `pix_clk` transition is the active edge; with it low, a high-to-low transition is. An edge is seen in the `clk` cycle in which `pix_clk` differs from its value one `clk` cycle earlier, and `pix_word` is taken only at the active edge.
- R4: A start strobe seen high at an active edge arms a run, and the word on that edge is not stored. The next active edge stores into channel 0 when `load_fwd` was high with the strobe, then channels 1 to 5 follow. When `load_fwd` was low, storing starts at channel 5 and proceeds downward to channel 0.
- R5: `xfer` is sampled on every rising `pix_clk` edge regardless of `rise_sel`. On the next rising edge, all six held words appear on `dac_code`. `dac_code` changes at no other time.
- R6: After the sixth word of a run, further words are ignored until the next start strobe.
- R7: Reset (`rst_n` low, asynchronous) clears all held words and outputs and leaves the loader idle, so words are ignored until a start strobe arrives.
- R8: While `standby` is high, words, start strobes and transfer strobes are ignored, and `dac_code` holds. A transfer already pending stays pending and completes on the first rising edge after standby ends.
- R9: If a pending transfer executes on the same edge that stores the sixth word, the output set includes that word.
- R10: A word presented with `inv_pol` high is stored as 1023 − n.
- R11: A start strobe during a run abandons it, and the next active edge stores into the first channel of the new direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least four times the pixel rate |
| rst_n | input | 1 | Asynchronous reset, active low |
| pix_clk | input | 1 | Pixel clock, sampled as data |
| rise_sel | input | 1 | 1: rising pixel edge active, 0: falling |
| load_fwd | input | 1 | 1: load from channel 0 upward, 0: from channel 5 downward |
| start_seq | input | 1 | Start strobe for a loading run |
| xfer | input | 1 | Transfer strobe for the output registers |
| standby | input | 1 | Freezes the block while high |
| inv_pol | input | 1 | Polarity flag of the present word |
| pix_word | input | 10 | Present pixel word |
| dac_code | output | 60 | Six output codes, channel k at [10k+9:10k] |

## Verification
The assertions assume the following about the inputs:

- `pix_clk` is synchronous to `clk` and holds each level for at least two `clk` cycles, so two edges never merge.
- Strobes and data are stable in the `clk` cycle in which an edge is detected.
- `pix_clk` sits at the idle level of the chosen edge mode when reset is released.

The stimulus meets these conditions by changing every input on falling `clk` edges and by holding each pixel level for two `clk` cycles. It also alters the word and the start strobe just after the active edge, so that a capture on the wrong edge shows up on `dac_code`. The edge mode is changed only under reset.

// File: rtl/pcl_pkg.sv
package pcl_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_LOAD  = 2'd2,
        ST_FULL  = 2'd3
    } ld_state_t;

    localparam int DEF_NUM_CH = 6;
    localparam int DEF_WORD_W = 10;

endpackage

// File: rtl/pcl_edge_detect.sv
module pcl_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic pix_clk,
    input  logic rise_sel,
    output logic pclk_q,
    output logic rise_edge,
    output logic act_edge
);
    logic fall_edge;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pclk_q <= 1'b0;
        else        pclk_q <= pix_clk;
    end

    always_comb begin
        rise_edge = pix_clk & ~pclk_q;
        fall_edge = ~pix_clk & pclk_q;
        act_edge  = rise_sel ? rise_edge : fall_edge;
    end
endmodule

// File: rtl/pcl_seq_fsm.sv
module pcl_seq_fsm
    import pcl_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_edge,
    input  logic              standby,
    input  logic              start_seq,
    input  logic              load_fwd,
    output ld_state_t         state,
    output logic [NUM_CH-1:0] wr_sel
);
    localparam int PTR_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(NUM_CH - 1);

    ld_state_t        state_nxt;
    logic [PTR_W-1:0] cnt, cnt_nxt;
    logic             dir_q, dir_nxt;
    logic             wr_go;
    logic [PTR_W-1:0] wr_idx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
            dir_q <= 1'b1;
        end else begin
            state <= state_nxt;
            cnt   <= cnt_nxt;
            dir_q <= dir_nxt;
        end
    end

    // next state
    always_comb begin
        state_nxt = state;
        cnt_nxt   = cnt;
        dir_nxt   = dir_q;
        if (act_edge && !standby) begin
            if (start_seq) begin
                state_nxt = ST_ARMED;
                cnt_nxt   = '0;
                dir_nxt   = load_fwd;
            end else begin
                unique case (state)
                    ST_IDLE: ;
                    ST_ARMED: begin
                        if (cnt == LAST) begin
                            state_nxt = ST_FULL;
                            cnt_nxt   = '0;
                        end else begin
                            state_nxt = ST_LOAD;
                            cnt_nxt   = cnt + PTR_W'(1);
                        end
                    end
                    ST_LOAD: begin
                        if (cnt == LAST) begin
                            state_nxt = ST_FULL;
                            cnt_nxt   = '0;
                        end else begin
                            cnt_nxt   = cnt + PTR_W'(1);
                        end
                    end
                    ST_FULL: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        wr_go  = act_edge && !standby && !start_seq &&
                 (state == ST_ARMED || state == ST_LOAD);
        wr_idx = dir_q ? cnt : (LAST - cnt);
        for (int c = 0; c < NUM_CH; c++) begin
            wr_sel[c] = wr_go && (wr_idx == PTR_W'(c));
        end
    end
endmodule

// File: rtl/pcl_hold_bank.sv
module pcl_hold_bank #(
    parameter int NUM_CH = 6,
    parameter int WORD_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        wr_sel,
    input  logic [WORD_W-1:0]        pix_word,
    input  logic                     inv_pol,
    output logic [NUM_CH*WORD_W-1:0] hold_q,
    output logic [NUM_CH*WORD_W-1:0] hold_nxt
);
    logic [WORD_W-1:0] coded;

    always_comb coded = inv_pol ? ~pix_word : pix_word;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        always_comb begin
            hold_nxt[g*WORD_W +: WORD_W] = wr_sel[g] ? coded
                                                     : hold_q[g*WORD_W +: WORD_W];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) hold_q[g*WORD_W +: WORD_W] <= '0;
            else        hold_q[g*WORD_W +: WORD_W] <= hold_nxt[g*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/pcl_out_bank.sv
module pcl_out_bank #(
    parameter int NUM_CH = 6,
    parameter int WORD_W = 10
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     rise_edge,
    input  logic                     standby,
    input  logic                     xfer,
    input  logic [NUM_CH*WORD_W-1:0] hold_nxt,
    output logic                     xfer_pend,
    output logic [NUM_CH*WORD_W-1:0] dac_code
);
    logic upd;

    always_comb upd = rise_edge && !standby;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   xfer_pend <= 1'b0;
        else if (upd) xfer_pend <= xfer;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_out
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                dac_code[g*WORD_W +: WORD_W] <= '0;
            else if (upd && xfer_pend)
                dac_code[g*WORD_W +: WORD_W] <= hold_nxt[g*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/pixel_chan_loader.sv
module pixel_chan_loader
    import pcl_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pix_clk,
    input  logic                     rise_sel,
    input  logic                     load_fwd,
    input  logic                     start_seq,
    input  logic                     xfer,
    input  logic                     standby,
    input  logic                     inv_pol,
    input  logic [WORD_W-1:0]        pix_word,
    output logic [NUM_CH*WORD_W-1:0] dac_code
);
    logic                     pclk_q;
    logic                     rise_edge;
    logic                     act_edge;
    ld_state_t                state;
    logic [NUM_CH-1:0]        wr_sel;
    logic [NUM_CH*WORD_W-1:0] hold_q;
    logic [NUM_CH*WORD_W-1:0] hold_nxt;
    logic                     xfer_pend;

    pcl_edge_detect u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .pix_clk   (pix_clk),
        .rise_sel  (rise_sel),
        .pclk_q    (pclk_q),
        .rise_edge (rise_edge),
        .act_edge  (act_edge)
    );

    pcl_seq_fsm #(.NUM_CH(NUM_CH)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_edge  (act_edge),
        .standby   (standby),
        .start_seq (start_seq),
        .load_fwd  (load_fwd),
        .state     (state),
        .wr_sel    (wr_sel)
    );

    pcl_hold_bank #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_sel   (wr_sel),
        .pix_word (pix_word),
        .inv_pol  (inv_pol),
        .hold_q   (hold_q),
        .hold_nxt (hold_nxt)
    );

    pcl_out_bank #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .rise_edge (rise_edge),
        .standby   (standby),
        .xfer      (xfer),
        .hold_nxt  (hold_nxt),
        .xfer_pend (xfer_pend),
        .dac_code  (dac_code)
    );
endmodule

// File: rtl/pcl_checker.sv
module pcl_checker
    import pcl_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int WORD_W = DEF_WORD_W
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pix_clk,
    input logic                     pclk_q,
    input logic                     act_edge,
    input logic                     standby,
    input logic                     start_seq,
    input ld_state_t                state,
    input logic [NUM_CH-1:0]        wr_sel,
    input logic [NUM_CH*WORD_W-1:0] hold_q,
    input logic [NUM_CH*WORD_W-1:0] dac_code
);
    AST_OUT_ONLY_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        (!(pix_clk && !pclk_q) || standby) |=> $stable(dac_code)); // R5

    AST_ONE_CHANNEL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)); // R2

    AST_FULL_IGNORES_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FULL && !start_seq) |=> $stable(hold_q)); // R6

    AST_NO_WRITE_WHEN_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_FULL) |-> (wr_sel == '0)); // R7

    AST_STANDBY_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        standby |=> ($stable(hold_q) && $stable(state) && $stable(dac_code))); // R8

    AST_START_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
        (act_edge && start_seq && !standby) |=> (state == ST_ARMED)); // R4
endmodule

bind pixel_chan_loader pcl_checker #(.NUM_CH(NUM_CH), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_clk   (pix_clk),
    .pclk_q    (pclk_q),
    .act_edge  (act_edge),
    .standby   (standby),
    .start_seq (start_seq),
    .state     (state),
    .wr_sel    (wr_sel),
    .hold_q    (hold_q),
    .dac_code  (dac_code)
);

// File: tb/tb_pixel_chan_loader.sv
module tb_pixel_chan_loader;
    localparam int NCH = 6;
    localparam int WW  = 10;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            pix_clk = 1'b0;
    logic            rise_sel = 1'b1;
    logic            load_fwd = 1'b1;
    logic            start_seq = 1'b0;
    logic            xfer = 1'b0;
    logic            standby = 1'b0;
    logic            inv_pol = 1'b0;
    logic [WW-1:0]   pix_word = '0;
    logic [NCH*WW-1:0] dac_code;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    pixel_chan_loader #(.NUM_CH(NCH), .WORD_W(WW)) dut (
        .clk(clk), .rst_n(rst_n), .pix_clk(pix_clk), .rise_sel(rise_sel),
        .load_fwd(load_fwd), .start_seq(start_seq), .xfer(xfer),
        .standby(standby), .inv_pol(inv_pol), .pix_word(pix_word),
        .dac_code(dac_code)
    );

    // reference model, written from the requirements
    logic [WW-1:0] m_hold [NCH];
    logic [WW-1:0] m_out  [NCH];
    int  m_st;   // 0 idle, 1 armed, 2 load, 3 full
    int  m_cnt;
    bit  m_dir;
    bit  m_pend;

    logic [NCH*WW-1:0] exp_q[$];
    string             tag_q[$];
    event              chk_ev;

    task automatic model_clear();
        for (int k = 0; k < NCH; k++) begin
            m_hold[k] = '0;
            m_out[k]  = '0;
        end
        m_st = 0; m_cnt = 0; m_dir = 1'b1; m_pend = 1'b0;
    endtask

    task automatic model_edge(bit is_rise);
        logic [WW-1:0] hn [NCH];
        bit act;
        int idx;
        if (standby) return;
        act = rise_sel ? is_rise : !is_rise;
        hn = m_hold;
        if (act) begin
            if (start_seq) begin
                m_st = 1; m_dir = load_fwd; m_cnt = 0;
            end else if (m_st == 1 || m_st == 2) begin
                idx = m_dir ? m_cnt : (NCH - 1 - m_cnt);
                hn[idx] = inv_pol ? (WW'(1023) - pix_word) : pix_word;   // R10
                if (m_cnt == NCH - 1) begin
                    m_st = 3; m_cnt = 0;
                end else begin
                    m_cnt++; m_st = 2;
                end
            end
        end
        if (is_rise) begin
            if (m_pend) m_out = hn;
            m_pend = xfer;
        end
        m_hold = hn;
    endtask

    task automatic push_expect(string tag);
        logic [NCH*WW-1:0] v;
        for (int k = 0; k < NCH; k++) v[k*WW +: WW] = m_out[k];  // R1 packing
        exp_q.push_back(v);
        tag_q.push_back(tag);
        ->chk_ev;
    endtask

    // driver: one pixel period; the word and start change right after the active edge
    task automatic pix(logic [WW-1:0] w, bit inv, bit st, bit xf, bit fwd, bit sb,
                       string tag);
        @(negedge clk);
        pix_word = w; inv_pol = inv; start_seq = st; xfer = xf;
        load_fwd = fwd; standby = sb;
        pix_clk = ~pix_clk;
        model_edge(pix_clk);
        repeat (2) @(negedge clk);
        pix_word = ~w; inv_pol = ~inv; start_seq = 1'b0;
        pix_clk = ~pix_clk;
        model_edge(pix_clk);
        repeat (2) @(negedge clk);
        push_expect(tag);
    endtask

    task automatic do_reset(bit rmode);
        @(negedge clk);
        rst_n = 1'b0; rise_sel = rmode; pix_clk = ~rmode;
        start_seq = 1'b0; xfer = 1'b0; standby = 1'b0; inv_pol = 1'b0;
        pix_word = '0; load_fwd = 1'b1;
        model_clear();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        push_expect("R7 reset state");
    endtask

    task automatic load_six(logic [WW-1:0] base, bit fwd, bit inv_odd, string tag);
        for (int i = 0; i < NCH; i++)
            pix(base + WW'(i * 7), inv_odd && (i % 2 == 1), 1'b0, 1'b0, fwd, 1'b0, tag);
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                logic [NCH*WW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (dac_code !== e) begin
                    fails++;
                    $display("FAIL %s: dac_code actual=%h expected=%h", t, dac_code, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        // rising-edge mode
        do_reset(1'b1);
        pix(10'd77, 0, 0, 1, 1, 0, "R7 word before start ignored");
        pix(10'd1, 0, 0, 0, 1, 0, "R7 transfer after reset");
        pix(10'd999, 0, 1, 0, 1, 0, "R4 start word not stored");
        load_six(10'd100, 1'b1, 1'b0, "R2 forward load");
        pix(10'd555, 0, 0, 1, 1, 0, "R5 transfer sampled, not yet applied");
        pix(10'd556, 0, 0, 0, 1, 0, "R5 R1 R4 forward set on outputs");
        pix(10'd300, 1, 0, 0, 1, 0, "R6 extra word after full");
        pix(10'd301, 0, 0, 1, 1, 0, "R6 transfer request");
        pix(10'd302, 0, 0, 0, 1, 0, "R6 outputs unchanged by ignored words");

        // reverse order, polarity, transfer coinciding with last word
        pix(10'd0, 0, 1, 0, 0, 0, "R4 reverse start");
        for (int i = 0; i < NCH - 1; i++)
            pix(10'd200 + 10'(i * 11), (i % 2 == 0), 0, (i == NCH - 2), 1, 0,
                "R10 R4 reverse load");
        pix(10'd1023, 1, 0, 0, 1, 0, "R9 last word with transfer");
        pix(10'd0, 0, 0, 0, 1, 0, "R9 outputs hold after");

        // restart during a run
        pix(10'd0, 0, 1, 0, 1, 0, "R11 first start");
        pix(10'd11, 0, 0, 0, 1, 0, "R11 partial");
        pix(10'd12, 0, 0, 0, 1, 0, "R11 partial");
        pix(10'd13, 0, 1, 0, 0, 0, "R11 restart reverse");
        load_six(10'd400, 1'b0, 1'b1, "R11 restarted load");
        pix(10'd0, 0, 0, 1, 1, 0, "R11 transfer");
        pix(10'd0, 0, 0, 0, 1, 0, "R11 restarted set on outputs");

        // standby
        pix(10'd0, 0, 1, 0, 1, 0, "R8 start before standby");
        pix(10'd50, 0, 0, 1, 1, 0, "R8 first word, transfer pending");
        pix(10'd60, 0, 1, 1, 1, 1, "R8 standby ignores start and transfer");
        pix(10'd61, 1, 0, 0, 0, 1, "R8 standby ignores word");
        pix(10'd62, 0, 0, 0, 1, 0, "R8 pending transfer after standby");
        pix(10'd63, 0, 0, 1, 1, 0, "R8 transfer request");
        pix(10'd64, 0, 0, 0, 1, 0, "R8 load continued after standby");

        // falling-edge mode
        do_reset(1'b0);
        pix(10'd0, 0, 1, 0, 1, 0, "R3 start on falling edge");
        load_six(10'd700, 1'b1, 1'b1, "R3 falling-edge load");
        pix(10'd0, 0, 0, 1, 1, 0, "R3 transfer request");
        pix(10'd0, 0, 0, 0, 1, 0, "R3 falling-edge set on outputs");
        pix(10'd0, 0, 1, 0, 0, 0, "R3 reverse start falling");
        for (int i = 0; i < NCH; i++)
            pix(10'd30 + 10'(i), 0, 0, (i == NCH - 2), 1, 0, "R9 falling last word");
        pix(10'd0, 0, 0, 0, 1, 0, "R9 falling outputs");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule